// File: doc/BRIEF.md
# Compare-Based PWM Timer

This block is a 16-bit timer whose counter advances on a prescaled tick and whose output pin is steered by two byte-programmable compare channels. The tick comes either from the system clock divided by 2, 4 or 8 or from an external strobe. In free-running operation the counter wraps from FFFFh to 0000h. Each compare match drives the pin to a programmed level and raises a match flag that can request an interrupt.

When PWM operation is selected, channel 1 sets the pin level that starts the pulse. Channel 2 sets the level that ends the cycle, restarts the counter at FFFCh and raises a period flag. This gives a period of (compare 2 + 5) ticks and a pulse of (compare 2 − compare 1) ticks. A one-pulse mode bit also exists. When it is set together with the PWM bit, PWM behaviour takes precedence. Software loads each compare value as a high byte then a low byte, and a channel ignores matches between those two writes.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the pin, all three flags and the interrupt read 0, and the counter starts at FFFCh, so the first PWM cycle follows the same timing as every later one.
- R2: The control field at bits [1:0] of register 0 selects the tick source: 0 gives one tick every 2 clocks, 1 every 4, 2 every 8, and 3 takes one tick per clock in which `ext_tick` is high. The counter and the pin change only on a tick.
- R3: On the tick in which the counter equals compare 1 (channel enabled), the pin takes the level bit at control bit 2 after that tick.
- R4: With PWM enabled (control bit 4), on the tick in which the counter equals compare 2, the pin takes the level bit at control bit 3 and the counter reloads to FFFCh. The PWM period is therefore (compare 2 + 5) ticks.
- R5: A compare 2 match in PWM sets the period flag (flag bit 0). `irq` is high when the flag is set, the period-interrupt enable (control bit 6) is 1 and `irq_mask` is 0.
- R6: While PWM is enabled, the compare flags (flag bits 1 and 2) are never set.
- R7: Outside PWM the counter wraps from FFFFh to 0000h. Compare 1 and compare 2 matches set flag bits 1 and 2, and with the compare-interrupt enable (control bit 7) set and `irq_mask` 0, either flag drives `irq` high.
- R8: Writing a compare high byte (register 1 for channel 1, register 3 for channel 2) disables that channel until its low byte (register 2 or 4) is written.
- R9: With the one-pulse bit (control bit 5) and the PWM bit both set, the block behaves exactly as in PWM.
- R10: With both level bits equal, the pin stays constant. With level 1 = 1 and level 2 = 0, the pin is high for (compare 2 − compare 1) ticks per period.
- R11: Writing register 5 clears each flag whose data bit is 1. A flag that hardware sets in the same clock stays set.
- R12: When both channels match on the same tick, the pin takes the level of channel 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External count strobe, one pulse per count, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1/2 compare 1 high/low, 3/4 compare 2 high/low, 5 flag clear |
| wr_data | input | 8 | Write data |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks `irq` |
| pwm_out | output | 1 | Timer output pin |
| flags | output | 3 | Bit 0 period flag, bit 1 compare 1 flag, bit 2 compare 2 flag |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. Compare values and control bits therefore apply from the next tick, and a flag clear is visible one clock after its write edge. Pin, counter and flag updates appear right after the clock edge that carries the matching tick. `irq` follows the flags and `irq_mask` with no added delay. The bench drives all inputs and samples all outputs on the falling edge, so every result is read half a clock after the edge that produced it. Pulse and period widths are counted in whole clocks between falling-edge samples, which makes them exact multiples of the tick spacing.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int ADDR_W = 3;

  // register selects
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd5;

  // first compare register select; channel i high byte at base+2i, low at base+2i+1
  localparam int A_CMP_BASE = 1;

  // control bit positions
  localparam int CB_SEL   = 0;
  localparam int CB_LVL1  = 2;
  localparam int CB_LVL2  = 3;
  localparam int CB_PWM   = 4;
  localparam int CB_OPM   = 5;
  localparam int CB_CAPIE = 6;
  localparam int CB_CMPIE = 7;

  // flag bit positions
  localparam int NFLAG  = 3;
  localparam int F_PER  = 0;
  localparam int F_CMP1 = 1;
  localparam int F_CMP2 = 2;

  localparam int NCMP = 2;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_PWM    = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic pwm_bit, input logic opm_bit);
    if (pwm_bit)      return MODE_PWM;
    else if (opm_bit) return MODE_SINGLE;
    else              return MODE_FREE;
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(input int ch, input int lo);
    return ADDR_W'(A_CMP_BASE + 2 * ch + lo);
  endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_tick,
  output logic             tick
);

  localparam int NSEL    = 1 << SEL_W;
  localparam int DIV_MAX = 2 << (NSEL - 2);
  localparam int DIV_W   = $clog2(DIV_MAX);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] div_lim;
  logic             use_ext;
  logic             int_tick;

  always_comb begin
    use_ext  = (sel == {SEL_W{1'b1}});
    div_lim  = DIV_W'((2 << sel) - 1);
    int_tick = (div_q >= div_lim);
    tick     = use_ext ? ext_tick : int_tick;
    if (use_ext || int_tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare #(
  parameter int                    BYTE_W  = 8,
  parameter logic [2*BYTE_W-1:0]   RST_VAL = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [BYTE_W-1:0]   wr_byte,
  input  logic [2*BYTE_W-1:0] cnt,
  output logic                match
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] val_d;
  logic             armed_q;
  logic             armed_d;
  logic             load_en;

  always_comb begin
    val_d   = val_q;
    armed_d = armed_q;
    load_en = wr_hi | wr_lo;
    if (wr_hi) begin
      val_d[CNT_W-1:BYTE_W] = wr_byte;
      armed_d               = 1'b0;
    end else if (wr_lo) begin
      val_d[BYTE_W-1:0] = wr_byte;
      armed_d           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= RST_VAL;
      armed_q <= 1'b1;
    end else if (load_en) begin
      val_q   <= val_d;
      armed_q <= armed_d;
    end
  end

  assign match = armed_q && (cnt == val_q);

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
  import pwmt_pkg::*;
#(
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  mode_e            mode,
  input  logic             lvl1,
  input  logic             lvl2,
  input  logic             m1,
  input  logic             m2,
  input  logic [NFLAG-1:0] clr,
  output logic [CNT_W-1:0] cnt,
  output logic             pin,
  output logic [NFLAG-1:0] flags
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             pin_q;
  logic             pin_d;
  logic [NFLAG-1:0] flg_q;
  logic [NFLAG-1:0] flg_d;
  logic [NFLAG-1:0] hw_set;
  logic             pwm_on;

  always_comb begin
    pwm_on = (mode == MODE_PWM);
    cnt_d  = cnt_q + 1'b1;
    pin_d  = pin_q;
    hw_set = '0;
    if (pwm_on && m2) begin
      cnt_d          = RELOAD;
      pin_d          = lvl2;
      hw_set[F_PER]  = 1'b1;
    end else begin
      if (m1) pin_d = lvl1;
      if (m2) pin_d = lvl2;
      if (!pwm_on) begin
        hw_set[F_CMP1] = m1;
        hw_set[F_CMP2] = m2;
      end
    end
    if (!tick) hw_set = '0;
    flg_d = (flg_q & ~clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      pin_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      pin_q <= pin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      flg_q <= flg_d;
    end
  end

  assign cnt   = cnt_q;
  assign pin   = pin_q;
  assign flags = flg_q;

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwmt_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SEL_W      = 2,
  parameter int RELOAD_GAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              irq_mask,
  output logic              pwm_out,
  output logic [NFLAG-1:0]  flags,
  output logic              irq
);

  localparam int               CNT_W  = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}} - CNT_W'(RELOAD_GAP);

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] ctrl_d;
  logic              ctrl_we;
  logic [NFLAG-1:0]  clr_w;
  logic [NCMP-1:0]   wr_hi_w;
  logic [NCMP-1:0]   wr_lo_w;
  logic [NCMP-1:0]   match_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              tick_w;
  logic              pwm_active_w;
  mode_e             mode_w;

  // control register
  always_comb begin
    ctrl_we = wr_en && (wr_addr == A_CTRL);
    ctrl_d  = wr_data;
    clr_w   = (wr_en && (wr_addr == A_CLR)) ? wr_data[NFLAG-1:0] : '0;
    mode_w  = decode_mode(ctrl_q[CB_PWM], ctrl_q[CB_OPM]);
    pwm_active_w = (mode_w == MODE_PWM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  pwmt_prescaler #(
    .SEL_W (SEL_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ctrl_q[CB_SEL +: SEL_W]),
    .ext_tick (ext_tick),
    .tick     (tick_w)
  );

  for (genvar ch = 0; ch < NCMP; ch++) begin : gen_ch
    always_comb begin
      wr_hi_w[ch] = wr_en && (wr_addr == cmp_addr(ch, 0));
      wr_lo_w[ch] = wr_en && (wr_addr == cmp_addr(ch, 1));
    end

    pwmt_compare #(
      .BYTE_W  (BYTE_W),
      .RST_VAL ({CNT_W{1'b1}})
    ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi_w[ch]),
      .wr_lo   (wr_lo_w[ch]),
      .wr_byte (wr_data),
      .cnt     (cnt_w),
      .match   (match_w[ch])
    );
  end

  pwmt_core #(
    .CNT_W  (CNT_W),
    .RELOAD (RELOAD)
  ) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w),
    .mode  (mode_w),
    .lvl1  (ctrl_q[CB_LVL1]),
    .lvl2  (ctrl_q[CB_LVL2]),
    .m1    (match_w[0]),
    .m2    (match_w[1]),
    .clr   (clr_w),
    .cnt   (cnt_w),
    .pin   (pwm_out),
    .flags (flags)
  );

  always_comb begin
    irq = !irq_mask &&
          ((ctrl_q[CB_CAPIE] && flags[F_PER]) ||
           (ctrl_q[CB_CMPIE] && (flags[F_CMP1] || flags[F_CMP2])));
  end

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD = 16'hFFFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             pwm_active,
  input logic             m2,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_out,
  input logic [2:0]       flags,
  input logic             irq,
  input logic             irq_mask
);

  // R4
  reload_after_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_active && m2) |=> (cnt == RELOAD));

  // R6
  no_cmp_flag_in_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_active |=> (!$rose(flags[1]) && !$rose(flags[2])));

  // R5
  period_flag_pwm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_active |=> !$rose(flags[0]));

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt) && $stable(pwm_out)));

  // R5
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

endmodule

bind pwm_cmp_timer pwmt_checker #(
  .CNT_W  (CNT_W),
  .RELOAD (RELOAD)
) u_pwmt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .pwm_active (pwm_active_w),
  .m2         (match_w[1]),
  .cnt        (cnt_w),
  .pwm_out    (pwm_out),
  .flags      (flags),
  .irq        (irq),
  .irq_mask   (irq_mask)
);

// File: tb/test_pwm_cmp_timer.sv
module test_pwm_cmp_timer;

  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       ext_tick;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq_mask;
  logic       pwm_out;
  logic [2:0] flags;
  logic       irq;

  pwm_cmp_timer i_pwm_cmp_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_tick (ext_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_mask (irq_mask),
    .pwm_out  (pwm_out),
    .flags    (flags),
    .irq      (irq)
  );

  int checks = 0;
  int errors = 0;
  int ext_mode = 0;
  int ext_cnt = 0;

  // reference model state
  logic [2:0]  m_div;
  logic [15:0] m_cnt, m_oc1, m_oc2;
  logic        m_en1, m_en2, m_pin;
  logic [7:0]  m_ctrl;
  logic [2:0]  m_flg;

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  function automatic int f_period(input int oc2, input int div);
    return (oc2 + 5) * div;
  endfunction

  function automatic int f_high(input int oc1, input int oc2, input int div);
    return (oc2 - oc1) * div;
  endfunction

  function automatic logic f_irq(input logic [7:0] c, input logic [2:0] f, input logic msk);
    return !msk && ((c[6] && f[0]) || (c[7] && (f[1] || f[2])));
  endfunction

  task automatic model_reset();
    m_div = 0; m_cnt = 16'hFFFC; m_oc1 = 16'hFFFF; m_oc2 = 16'hFFFF;
    m_en1 = 1; m_en2 = 1; m_pin = 0; m_ctrl = 0; m_flg = 0;
  endtask

  task automatic model_step();
    logic       ext, itk, tk, mt1, mt2, pwm;
    logic [3:0] lim;
    logic [2:0] setf, clrf;
    ext  = (m_ctrl[1:0] == 2'd3);
    lim  = 4'((2 << m_ctrl[1:0]) - 1);
    itk  = ({1'b0, m_div} >= lim);
    tk   = ext ? ext_tick : itk;
    m_div = (ext || itk) ? 3'd0 : m_div + 3'd1;
    mt1  = m_en1 && (m_cnt == m_oc1);
    mt2  = m_en2 && (m_cnt == m_oc2);
    pwm  = m_ctrl[4];
    setf = 0;
    clrf = 0;
    if (tk) begin
      if (pwm && mt2) begin
        m_cnt = 16'hFFFC; m_pin = m_ctrl[3]; setf[0] = 1;
      end else begin
        m_cnt = m_cnt + 16'd1;
        if (mt1) m_pin = m_ctrl[2];
        if (mt2) m_pin = m_ctrl[3];
        if (!pwm) begin setf[1] = mt1; setf[2] = mt2; end
      end
    end
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_ctrl = wr_data;
        3'd1: begin m_oc1[15:8] = wr_data; m_en1 = 0; end
        3'd2: begin m_oc1[7:0]  = wr_data; m_en1 = 1; end
        3'd3: begin m_oc2[15:8] = wr_data; m_en2 = 0; end
        3'd4: begin m_oc2[7:0]  = wr_data; m_en2 = 1; end
        3'd5: clrf = wr_data[2:0];
        default: ;
      endcase
    end
    m_flg = (m_flg & ~clrf) | setf;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "pin", int'(pwm_out), int'(m_pin));
      chk("R11", "flags", int'(flags), int'(m_flg));
      chk("R5", "irq", int'(irq), int'(f_irq(m_ctrl, m_flg, irq_mask)));
    end
  end

  // external strobe driver
  always @(negedge clk) begin
    case (ext_mode)
      1: begin
        ext_cnt  = (ext_cnt == 2) ? 0 : ext_cnt + 1;
        ext_tick = (ext_cnt == 0);
      end
      2: ext_tick = ($urandom % 3) == 0;
      default: ext_tick = 1'b0;
    endcase
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_cmp(input int ch, input logic [15:0] v);
    wr(3'(1 + 2 * ch), v[15:8]);
    wr(3'(2 + 2 * ch), v[7:0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; irq_mask = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    logic prev;
    int   t;
    prev = pwm_out; t = 0;
    forever begin
      @(negedge clk);
      if (!prev && pwm_out) break;
      prev = pwm_out;
      t++;
      if (t > 5000) break;
    end
    hi = 0;
    while (pwm_out && hi < 5000) begin @(negedge clk); hi++; end
    per = hi;
    while (!pwm_out && per < 10000) begin @(negedge clk); per++; end
  endtask

  initial begin
    int hi, per, cnt_hi;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_mask = 1'b0; ext_tick = 1'b0;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1", "pin after reset", int'(pwm_out), 0);
    chk("R1", "flags after reset", int'(flags), 0);
    chk("R1", "irq after reset", int'(irq), 0);

    // R3 R4 R10 divide by 2
    do_reset();
    wr_cmp(0, 16'd10); wr_cmp(1, 16'd30); wr(3'd0, 8'h14);
    measure(hi, per);
    chk("R10", "high time /2", hi, f_high(10, 30, 2));
    chk("R4", "period /2", per, f_period(30, 2));

    // R9 one-pulse plus PWM
    do_reset();
    wr_cmp(0, 16'd10); wr_cmp(1, 16'd30); wr(3'd0, 8'h34);
    measure(hi, per);
    chk("R9", "high time both modes", hi, f_high(10, 30, 2));
    chk("R9", "period both modes", per, f_period(30, 2));

    // R2 divide by 8
    do_reset();
    wr_cmp(0, 16'd4); wr_cmp(1, 16'd12); wr(3'd0, 8'h16);
    measure(hi, per);
    chk("R2", "high time /8", hi, f_high(4, 12, 8));
    chk("R2", "period /8", per, f_period(12, 8));

    // R2 external strobe every 3 clocks
    do_reset();
    ext_mode = 1;
    wr_cmp(0, 16'd2); wr_cmp(1, 16'd6); wr(3'd0, 8'h17);
    measure(hi, per);
    chk("R2", "high time ext", hi, f_high(2, 6, 3));
    chk("R2", "period ext", per, f_period(6, 3));
    ext_mode = 0;

    // R12 simultaneous match, level 2 wins
    do_reset();
    wr_cmp(0, 16'd20); wr_cmp(1, 16'd20); wr(3'd0, 8'h14);
    cnt_hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (pwm_out) cnt_hi++; end
    chk("R12", "high samples with equal compares", cnt_hi, 0);

    // R10 equal levels hold the pin
    do_reset();
    wr_cmp(0, 16'd5); wr_cmp(1, 16'd20); wr(3'd0, 8'h1C);
    wait_clk(100);
    cnt_hi = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (pwm_out) cnt_hi++; end
    chk("R10", "high samples with equal levels", cnt_hi, 200);

    // R5 R6 R11 period flag, interrupt, mask and clear
    do_reset();
    wr_cmp(0, 16'd10); wr_cmp(1, 16'd30); wr(3'd0, 8'h54);
    wr(3'd5, 8'h07);
    wait_clk(150);
    chk("R5", "period flag", int'(flags[0]), 1);
    chk("R6", "compare flags in PWM", int'(flags[2:1]), 0);
    chk("R5", "irq with enable", int'(irq), 1);
    irq_mask = 1'b1;
    @(negedge clk);
    chk("R5", "irq masked", int'(irq), 0);
    irq_mask = 1'b0;
    wr(3'd5, 8'h01);
    chk("R11", "period flag after clear", int'(flags[0]), int'(m_flg[0]));

    // R8 channel disabled between high and low byte
    do_reset();
    wr_cmp(0, 16'd10); wr_cmp(1, 16'd30); wr(3'd0, 8'h14);
    wait_clk(150);
    wr(3'd5, 8'h07);
    wr(3'd3, 8'h00);
    wait_clk(300);
    chk("R8", "no reload while half written", int'(flags[0]), 0);
    chk("R8", "pin held at level 1", int'(pwm_out), 1);
    wr(3'd4, 8'hFF);
    wait_clk(600);
    chk("R8", "reload after low byte", int'(flags[0]), 1);

    // R7 free-running wrap and compare flag interrupt
    do_reset();
    wr(3'd0, 8'h80);
    wr_cmp(0, 16'h0040);
    wait_clk(20);
    wr(3'd5, 8'h07);
    wait_clk(180);
    chk("R7", "flags after wrap and match", int'(flags), 3'b010);
    chk("R7", "compare irq", int'(irq), 1);
    chk("R7", "pin with zero levels", int'(pwm_out), 0);

    // random stimulus against the model
    do_reset();
    ext_mode = 2;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (($urandom % 32) == 0) irq_mask = ~irq_mask;
      if (($urandom % 12) == 0) begin
        wr_en   = 1'b1;
        wr_addr = 3'($urandom % 6);
        case (wr_addr)
          3'd1, 3'd3: wr_data = 8'h00;
          3'd2, 3'd4: wr_data = 8'($urandom % 64);
          3'd0:       wr_data = 8'($urandom) | 8'h10;
          default:    wr_data = 8'($urandom);
        endcase
      end
    end
    wr_en = 1'b0;
    ext_mode = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule